// File: doc/BRIEF.md
# Dual-Path 32-bit Add/Subtract Execution Unit

This block is an execution unit for a media coprocessor. It takes one 32-bit instruction word at a time. Two source indices select operands from a 16-entry register file that lives inside the block. Two independent arithmetic lanes each produce either the sum or the difference of that same operand pair. Each lane writes its result to its own destination register and records a carry/borrow flag in a fixed high bit of a 32-bit control register.

A two-bit pattern field picks add or subtract for each lane separately. A nonzero padding field suppresses the whole instruction. A zero destination index switches off only the lane it belongs to. All register and control updates commit on the clock edge that samples the instruction. A one-cycle done pulse follows every recognised instruction, including suppressed ones. A plain write port preloads registers, and a read port plus the control output let the surroundings observe state.

Top module: `dual_addsub_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, all sixteen registers, `ctrl_word` and `done` become zero.
- R2: An instruction is recognised only when `insn_valid` is high, `insn_word[5:0]` equals 0x18 and `insn_word[31:26]` equals 0x1C. Any other word changes no register, leaves the control word alone and raises no `done`.
- R3: The field layout is: pattern in bits [25:24], pad in [23:22], destination B in [21:18], source 2 in [17:14], source 1 in [13:10] and destination A in [9:6]. If pad is nonzero, no register and no control bit changes.
- R4: If destination A and destination B are both zero, no register and no control bit changes.
- R5: Pattern bit 1 set makes lane A compute source1 minus source2, and clear makes it compute source1 plus source2, modulo 2^32. Pattern bit 0 selects the operation for lane B in the same way.
- R6: For an add lane, the flag is 1 when source1 is unsigned-greater than the wrapped sum.
- R7: For a subtract lane, the flag is 1 when source1 is unsigned-greater than source2.
- R8: Lane A's flag goes to `ctrl_word[31]` and lane B's flag to `ctrl_word[30]`. Bits [29:0] keep their value, which stays zero.
- R9: A lane whose destination index is zero writes no register and keeps its control flag bit. The other lane still executes.
- R10: Register 0 always reads as zero, and writes to it from the load port or from an instruction are ignored.
- R11: Both lanes use the operand values that were held before the instruction, even when a destination equals a source.
- R12: When both lanes name the same nonzero destination, lane B's result is the one stored.
- R13: `done` is high for exactly the one cycle after each edge that samples a recognised instruction, and register and control updates are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_valid | input | 1 | Instruction word is present this cycle |
| insn_word | input | 32 | Instruction word |
| ld_en | input | 1 | Register preload strobe (an instruction lane writing the same index wins) |
| ld_idx | input | 4 | Register preload index |
| ld_data | input | 32 | Register preload value |
| rb_idx | input | 4 | Register read-back index |
| rb_data | output | 32 | Register read-back value (combinational) |
| ctrl_word | output | 32 | Control register with lane flags in bits 31 and 30 |
| done | output | 1 | One-cycle pulse after a recognised instruction |

## Verification
The lanes are tried with all four pattern settings on operand pairs picked so that the flags separate cleanly. Small values give no carry. An all-ones plus one operand pair wraps to zero. Equal operands under subtract show that the flag is a strict comparison and not a borrow. A swapped operand order shows that subtract is not commutative. Further instructions differ from a normal one in a single field: pad set, each destination zeroed alone and both zeroed, destination equal to a source, both destinations equal, and a wrong function code. These show which suppression or ordering rule is in force, because the read-back registers and the two flag bits then diverge from the plain case.

// File: rtl/dpas_pkg.sv
// Package: encoding constants and decoded-instruction type shared by the
// dual-path add/subtract unit. Field positions are fixed by the encoding.
package dpas_pkg;
    localparam int IDX_W     = 4;
    localparam int NREGS     = 1 << IDX_W;
    localparam int OP_W      = 6;
    localparam int PAT_LSB   = 24;
    localparam int PAD_LSB   = 22;
    localparam int DSTB_LSB  = 18;
    localparam int SRC2_LSB  = 14;
    localparam int SRC1_LSB  = 10;
    localparam int DSTA_LSB  = 6;
    localparam int NLANES    = 2;

    typedef struct packed {
        logic             recog;   // opcode matched and valid
        logic             exec;    // instruction takes effect
        logic [IDX_W-1:0] src1;
        logic [IDX_W-1:0] src2;
        logic [IDX_W-1:0] dst_a;
        logic [IDX_W-1:0] dst_b;
        logic [1:0]       lane_we; // [0] lane A, [1] lane B
        logic [1:0]       lane_sub;// [0] lane A, [1] lane B
    } dpas_dec_t;
endpackage

// File: rtl/dpas_decode.sv
// Module: dpas_decode
// Splits an instruction word into fields and derives enables. Assumes the
// word is meaningful only when valid is high; purely combinational.
module dpas_decode
    import dpas_pkg::*;
#(
    parameter logic [OP_W-1:0] CLASS_CODE = 6'h1C,
    parameter logic [OP_W-1:0] FUNC_CODE  = 6'h18
) (
    input  logic        valid,
    input  logic [31:0] word,
    output dpas_dec_t   dec
);
    logic [1:0] pat;
    logic [1:0] pad;
    logic       match;

    // Field extraction and suppression rules.
    always_comb begin
        pat   = word[PAT_LSB +: 2];
        pad   = word[PAD_LSB +: 2];
        match = valid && (word[31:32-OP_W] == CLASS_CODE)
                      && (word[OP_W-1:0] == FUNC_CODE);
        dec.recog    = match;
        dec.src1     = word[SRC1_LSB +: IDX_W];
        dec.src2     = word[SRC2_LSB +: IDX_W];
        dec.dst_a    = word[DSTA_LSB +: IDX_W];
        dec.dst_b    = word[DSTB_LSB +: IDX_W];
        dec.exec     = match && (pad == 2'b00)
                       && ((dec.dst_a != '0) || (dec.dst_b != '0));
        dec.lane_we[0]  = dec.exec && (dec.dst_a != '0);
        dec.lane_we[1]  = dec.exec && (dec.dst_b != '0);
        dec.lane_sub[0] = pat[1];
        dec.lane_sub[1] = pat[0];
    end
endmodule

// File: rtl/dpas_lane.sv
// Module: dpas_lane
// One arithmetic lane: wrapped add or subtract plus the unsigned flag.
// Assumes both operands are the pre-instruction register values.
module dpas_lane #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              sub,
    output logic [DATA_W-1:0] result,
    output logic              flag
);
    // Result and flag selection for the chosen operation.
    always_comb begin
        if (sub) begin
            result = op_a - op_b;
            flag   = (op_a > op_b);
        end else begin
            result = op_a + op_b;
            flag   = (op_a > result);
        end
    end
endmodule

// File: rtl/dpas_regfile.sv
// Module: dpas_regfile
// Register file with index 0 hard-wired to zero, three combinational read
// ports and three write ports: preload (lowest), lane A, lane B (highest).
module dpas_regfile
    import dpas_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] rc_data,
    input  logic              w0_en,
    input  logic [IDX_W-1:0]  w0_idx,
    input  logic [DATA_W-1:0] w0_data,
    input  logic              w1_en,
    input  logic [IDX_W-1:0]  w1_idx,
    input  logic [DATA_W-1:0] w1_data,
    input  logic              w2_en,
    input  logic [IDX_W-1:0]  w2_idx,
    input  logic [DATA_W-1:0] w2_data
);
    logic [DATA_W-1:0] regs [NREGS];

    // Storage update; later writes in this block take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else begin
            if (w0_en && (w0_idx != '0)) regs[w0_idx] <= w0_data;
            if (w1_en && (w1_idx != '0)) regs[w1_idx] <= w1_data;
            if (w2_en && (w2_idx != '0)) regs[w2_idx] <= w2_data;
        end
    end

    // Read ports with the zero register forced.
    always_comb begin
        ra_data = (ra_idx == '0) ? '0 : regs[ra_idx];
        rb_data = (rb_idx == '0) ? '0 : regs[rb_idx];
        rc_data = (rc_idx == '0) ? '0 : regs[rc_idx];
    end
endmodule

// File: rtl/dpas_ctrl.sv
// Module: dpas_ctrl
// Control register holding one flag per lane in its top bits; other bits
// are preserved. Also produces the registered done pulse.
module dpas_ctrl #(
    parameter int CTRL_W = 32,
    parameter int NL     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recog,
    input  logic [NL-1:0]     flag_we,
    input  logic [NL-1:0]     flag_in,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              done_q
);
    logic [CTRL_W-1:0] ctrl_d;

    // Merge lane flags: lane k owns bit CTRL_W-1-k.
    always_comb begin
        ctrl_d = ctrl_q;
        for (int k = 0; k < NL; k++) begin
            if (flag_we[k]) ctrl_d[CTRL_W-1-k] = flag_in[k];
        end
    end

    // Register the control word and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            done_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            done_q <= recog;
        end
    end
endmodule

// File: rtl/dual_addsub_unit.sv
// Module: dual_addsub_unit (top)
// Decodes one instruction per cycle, reads two operands, runs two add/sub
// lanes and commits results and flags on the sampling edge. Assumes no
// pipelining; the preload port is for initialisation and observation.
module dual_addsub_unit
    import dpas_pkg::*;
#(
    parameter int              DATA_W     = 32,
    parameter logic [OP_W-1:0] CLASS_CODE = 6'h1C,
    parameter logic [OP_W-1:0] FUNC_CODE  = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [31:0]       insn_word,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              done
);
    dpas_dec_t          dec;
    logic [DATA_W-1:0]  opnd1;
    logic [DATA_W-1:0]  opnd2;
    logic [DATA_W-1:0]  lane_res [NLANES];
    logic [NLANES-1:0]  lane_flag;

    dpas_decode #(.CLASS_CODE(CLASS_CODE), .FUNC_CODE(FUNC_CODE)) u_dec (
        .valid (insn_valid),
        .word  (insn_word),
        .dec   (dec)
    );

    dpas_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec.src1),
        .ra_data (opnd1),
        .rb_idx  (dec.src2),
        .rb_data (opnd2),
        .rc_idx  (rb_idx),
        .rc_data (rb_data),
        .w0_en   (ld_en),
        .w0_idx  (ld_idx),
        .w0_data (ld_data),
        .w1_en   (dec.lane_we[0]),
        .w1_idx  (dec.dst_a),
        .w1_data (lane_res[0]),
        .w2_en   (dec.lane_we[1]),
        .w2_idx  (dec.dst_b),
        .w2_data (lane_res[1])
    );

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        dpas_lane #(.DATA_W(DATA_W)) u_lane (
            .op_a   (opnd1),
            .op_b   (opnd2),
            .sub    (dec.lane_sub[g]),
            .result (lane_res[g]),
            .flag   (lane_flag[g])
        );
    end

    dpas_ctrl #(.CTRL_W(DATA_W), .NL(NLANES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .recog   (dec.recog),
        .flag_we (dec.lane_we),
        .flag_in (lane_flag),
        .ctrl_q  (ctrl_word),
        .done_q  (done)
    );
endmodule

// File: rtl/dpas_checker.sv
// Module: dpas_checker
// Port-level properties of the dual add/sub unit, bound to the top.
module dpas_checker #(
    parameter int         DATA_W     = 32,
    parameter logic [5:0] CLASS_CODE = 6'h1C,
    parameter logic [5:0] FUNC_CODE  = 6'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_valid,
    input logic [31:0]       insn_word,
    input logic [3:0]        rb_idx,
    input logic [DATA_W-1:0] rb_data,
    input logic [DATA_W-1:0] ctrl_word,
    input logic              done
);
    logic hit;
    assign hit = insn_valid && (insn_word[31:26] == CLASS_CODE)
                            && (insn_word[5:0] == FUNC_CODE);

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_word == '0) && !done);

    p_done_after_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> done);

    p_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !done);

    p_pad_holds_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (insn_word[23:22] != 2'b00) |=> $stable(ctrl_word));

    p_zero_dests_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (insn_word[21:18] == 4'd0) && (insn_word[9:6] == 4'd0)
        |=> $stable(ctrl_word));

    p_lane_a_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit && (insn_word[9:6] == 4'd0) |=> $stable(ctrl_word[DATA_W-1]));

    p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_word[DATA_W-3:0] == '0);

    p_zero_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_idx == 4'd0) |-> (rb_data == '0));
endmodule

bind dual_addsub_unit dpas_checker #(
    .DATA_W(DATA_W), .CLASS_CODE(CLASS_CODE), .FUNC_CODE(FUNC_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_valid (insn_valid),
    .insn_word  (insn_word),
    .rb_idx     (rb_idx),
    .rb_data    (rb_data),
    .ctrl_word  (ctrl_word),
    .done       (done)
);

// File: tb/dual_addsub_unit_bench.sv
// Scoreboard bench: the driver computes expected control words from the
// requirements and queues them; a monitor pops one per done pulse.
module dual_addsub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;
    logic [3:0]  rb_idx = '0;
    logic [31:0] rb_data;
    logic [31:0] ctrl_word;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [31:0] model [16];
    logic [31:0] mctrl;
    logic [31:0] expq [$];

    always #5 clk = ~clk;

    dual_addsub_unit u_dual_addsub_unit (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
        .rb_idx(rb_idx), .rb_data(rb_data), .ctrl_word(ctrl_word), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: each done pulse pops one expected control word.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (expq.size() == 0) check("R2 unexpected done", 32'd1, 32'd0);
            else check("R13/R8 ctrl on done", ctrl_word, expq.pop_front());
        end
    end

    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        ld_en = 1'b1; ld_idx = idx; ld_data = val;
        @(posedge clk); @(negedge clk);
        ld_en = 1'b0;
        if (idx != 0) model[idx] = val;
    endtask

    task automatic rdchk(input string req, input logic [3:0] idx);
        rb_idx = idx; #1;
        check(req, rb_data, (idx == 0) ? 32'd0 : model[idx]);
    endtask

    // Driver: issue one instruction, update the model, queue expectation.
    task automatic issue(input logic [5:0] cls, input logic [5:0] fn,
                         input logic [1:0] pat, input logic [1:0] pad,
                         input logic [3:0] db, input logic [3:0] s2,
                         input logic [3:0] s1, input logic [3:0] da);
        logic [31:0] a, b, r;
        logic f;
        a = (s1 == 0) ? 32'd0 : model[s1];
        b = (s2 == 0) ? 32'd0 : model[s2];
        if (cls == 6'h1C && fn == 6'h18) begin
            if (pad == 2'b00 && (da != 0 || db != 0)) begin
                if (da != 0) begin
                    r = pat[1] ? a - b : a + b;
                    f = pat[1] ? (a > b) : (a > r);
                    model[da] = r; mctrl[31] = f;
                end
                if (db != 0) begin
                    r = pat[0] ? a - b : a + b;
                    f = pat[0] ? (a > b) : (a > r);
                    model[db] = r; mctrl[30] = f;
                end
            end
            expq.push_back(mctrl);
        end
        insn_word = {cls, pat, pad, db, s2, s1, da, fn};
        insn_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        insn_valid = 1'b0;
        #1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        mctrl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 ctrl after reset", ctrl_word, 32'd0);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        for (int i = 1; i < 16; i++) rdchk("R1 reg after reset", 4'(i));
        rst_n = 1'b1;
        @(negedge clk);

        load(1, 32'd5); load(2, 32'd3); load(3, 32'hFFFF_FFFF);
        load(4, 32'd1); load(5, 32'h8000_0000); load(6, 32'd7);
        load(0, 32'hDEAD_BEEF);
        rdchk("R10 preload to r0 ignored", 0);

        // R5 R6 add/add, no carry
        issue(6'h1C, 6'h18, 2'b00, 2'b00, 4'd8, 4'd2, 4'd1, 4'd7);
        rdchk("R5 lane A add", 7); rdchk("R5 lane B add", 8);
        // R5 R7 sub/sub swapped order
        issue(6'h1C, 6'h18, 2'b11, 2'b00, 4'd8, 4'd1, 4'd2, 4'd7);
        rdchk("R7 lane A sub wraps", 7); rdchk("R7 lane B sub", 8);
        // R6 R7 mixed: A sub, B add with wrap to zero
        issue(6'h1C, 6'h18, 2'b10, 2'b00, 4'd10, 4'd4, 4'd3, 4'd9);
        rdchk("R5 lane A sub mixed", 9); rdchk("R6 lane B add wraps", 10);
        // R7 equal operands: A add wraps, B sub of equals gives flag 0
        issue(6'h1C, 6'h18, 2'b01, 2'b00, 4'd12, 4'd5, 4'd5, 4'd11);
        rdchk("R6 lane A add top bits", 11); rdchk("R7 lane B equal sub", 12);
        // R3 pad nonzero: nothing changes
        issue(6'h1C, 6'h18, 2'b00, 2'b01, 4'd13, 4'd2, 4'd1, 4'd7);
        rdchk("R3 pad blocks A", 7); rdchk("R3 pad blocks B", 13);
        // R4 both destinations zero
        issue(6'h1C, 6'h18, 2'b11, 2'b00, 4'd0, 4'd2, 4'd1, 4'd0);
        rdchk("R4 zero dests", 0);
        // R9 lane A off, lane B runs (sub 3-5, flag 0)
        issue(6'h1C, 6'h18, 2'b01, 2'b00, 4'd13, 4'd1, 4'd2, 4'd0);
        rdchk("R9 lane B alone", 13);
        // R9 lane B off, lane A runs (add 7+1)
        issue(6'h1C, 6'h18, 2'b00, 2'b00, 4'd0, 4'd4, 4'd6, 4'd14);
        rdchk("R9 lane A alone", 14);
        // R11 destination equals source
        issue(6'h1C, 6'h18, 2'b01, 2'b00, 4'd2, 4'd2, 4'd1, 4'd1);
        rdchk("R11 lane A old operands", 1); rdchk("R11 lane B old operands", 2);
        // R12 same destination: lane B (add) wins
        issue(6'h1C, 6'h18, 2'b10, 2'b00, 4'd15, 4'd4, 4'd6, 4'd15);
        rdchk("R12 lane B wins", 15);
        // R2 wrong function code and wrong class code
        issue(6'h1C, 6'h19, 2'b00, 2'b00, 4'd8, 4'd2, 4'd1, 4'd7);
        rdchk("R2 wrong func A", 7); rdchk("R2 wrong func B", 8);
        issue(6'h1D, 6'h18, 2'b00, 2'b00, 4'd8, 4'd2, 4'd1, 4'd7);
        rdchk("R2 wrong class", 7);
        check("R2 ctrl unchanged", ctrl_word, mctrl);

        repeat (2) @(negedge clk);
        check("R13 all expected done pulses seen", 32'(expq.size()), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule